// File: doc/BRIEF.md
# Addressed I2C Transaction Sequencer

This block turns one high-level request into the full series of byte-level commands that a bit-level I2C engine needs for a complete transfer to an addressed slave such as a serial EEPROM. A request names the operation (probe, write or read), a 7-bit device address, a register address of zero to `ADDR_BYTES` bytes and a byte count. The sequencer issues START, STOP, byte-write and byte-read commands to the engine one at a time. It checks every acknowledge the engine reports and decides from it whether to go on, count a failure or close the bus early.

Write payload is pulled from a valid/ready input stream and read payload is pushed out on a valid/ready output stream. For a read, the register address is first set by a write phase. The turnaround to the read phase is either STOP followed by START or a repeated START alone, selected by a configuration input. An optional fold mask merges the register-address bits above the transmitted address bytes into the low device-address bits, so that one large memory answers as several 256-byte devices. Every transfer ends with a STOP and a one-cycle completion pulse carrying a status code and a data-NACK count.

Top module: `i2cseq_top`

## Requirements
- R1: A probe (`req_op`=0) emits START, the device byte `{chip,0}` and STOP. It ignores the address length and count, and reports status 0 on ACK or 1 on NACK.
- R2: In a write (`req_op`=1), a NACK on the device byte `{chip,0}` is followed at once by STOP. No address or data byte is sent and the status is 1.
- R3: Register-address bytes are sent most significant first, exactly `req_alen` of them, right after an acknowledged device byte.
- R4: A NACK on any register-address byte is followed at once by STOP, with status 2 and a failure count of 0.
- R5: A NACK on a write data byte does not stop the transfer. All `req_len` bytes are sent, then STOP, and the status is 3 with the count of NACKed data bytes. The status is 3 exactly when that count is nonzero.
- R6: A read (`req_op`=2) with a nonzero address length sends START, `{chip,0}` and the address bytes. It then sends STOP followed by START when `cfg_rep_start`=0, or START alone when it is 1, and then `{chip,1}`.
- R7: A read with an address length of 0 sends START and then `{chip,1}` directly, with no write phase.
- R8: Read bytes are requested with ACK except the last, which is requested with NACK. They are delivered in order on the read stream, held stable while not accepted, and STOP follows the last one.
- R9: The device address actually sent is `chip | ((addr >> 8*alen) & cfg_fold_mask)`, in both the write and the read phase. A mask of 0 leaves the device address unchanged.
- R10: A NACK on the read device byte `{chip,1}` sets status 1, but the read bytes and STOP are still issued.
- R11: A read or write with `req_len`=0 sends only its addressing phases and STOP, and reports status 0.
- R12: After reset the block is idle: `req_ready`=1 and `cmd_valid`, `done_valid`, `rd_valid` and `wr_ready` are 0.
- R13: The engine command encoding is 0 START, 1 STOP, 2 byte write, 3 byte read (with `cmd_nack` selecting NACK). A command stays valid and unchanged until accepted, and the next one waits for the engine's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 2 | 0 probe, 1 write, 2 read |
| req_chip | input | 7 | 7-bit device address |
| req_addr | input | 8*ADDR_BYTES | Register address |
| req_alen | input | ALEN_W | Register address bytes to send |
| req_len | input | LEN_W | Data byte count |
| cfg_rep_start | input | 1 | 1: repeated START before read phase |
| cfg_fold_mask | input | 7 | Mask of address bits folded into device address |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Engine command present |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 2 | Engine command code |
| cmd_byte | output | 8 | Byte to transmit |
| cmd_nack | output | 1 | For a byte read: answer with NACK |
| rsp_valid | input | 1 | Engine finished the last command |
| rsp_nack | input | 1 | Slave NACKed the transmitted byte |
| rsp_data | input | 8 | Byte received by a byte read |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 no device, 2 address NACK, 3 data NACK |
| done_fail_cnt | output | LEN_W | Number of NACKed write data bytes |

## Verification
A wrong state or counter in the sequencer shows up first in the command transcript the engine sees. A phase taken too early or too late adds, drops or reorders a START, STOP or byte within a few commands of the error. The bench therefore records every accepted command and compares the whole transcript, together with status, failure count and delivered read bytes, against a transcript built independently from the requirements. An off-by-one in the remaining-byte or address-index counters changes the transcript length or the position of the single NACKed read on the very transfer where it occurs.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [1:0] {
        OP_PROBE = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_STOP  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_READ  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_NODEV     = 2'd1,
        ST_ADDR_NACK = 2'd2,
        ST_DATA_NACK = 2'd3
    } status_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_CHIPW, S_ADDR, S_MIDSTOP, S_CHIPR,
        S_WFETCH, S_WDATA, S_RDATA, S_RDOUT, S_STOP, S_DONE
    } state_e;

    function automatic logic [7:0] dev_frame(input logic [6:0] dev, input logic rd);
        return {dev, rd};
    endfunction

endpackage

// File: rtl/i2cseq_chipfold.sv
module i2cseq_chipfold #(
    parameter int ADDR_BYTES = 4,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int ALEN_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic [6:0]        chip,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ALEN_W-1:0] alen,
    input  logic [6:0]        mask,
    output logic [6:0]        chip_out
);
    logic [ADDR_W+6:0] wide;
    logic [ADDR_W+6:0] above;

    always_comb begin
        wide     = {7'd0, addr};
        above    = wide >> {alen, 3'b000};
        chip_out = chip | (above[6:0] & mask);
    end
endmodule

// File: rtl/i2cseq_addrbyte.sv
module i2cseq_addrbyte #(
    parameter int ADDR_BYTES = 4,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  idx,
    output logic [7:0]        byte_out
);
    logic [7:0] lane [ADDR_BYTES];

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign lane[g] = addr[8*g +: 8];
    end

    always_comb begin
        byte_out = 8'h00;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (IDX_W'(k) == idx) byte_out = lane[k];
        end
    end
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int LEN_W      = 8,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int ALEN_W = $clog2(ADDR_BYTES + 1),
    localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [6:0]        req_chip,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              cfg_rep_start,
    input  logic [6:0]        cfg_fold_mask,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [7:0]        cmd_byte,
    output logic              cmd_nack,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic [7:0]        rsp_data,
    output logic              done_valid,
    output logic [1:0]        done_status,
    output logic [LEN_W-1:0]  done_fail_cnt
);
    state_e            state;
    logic              waiting;
    op_e               op_q;
    logic [6:0]        chip_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ALEN_W-1:0] alen_q;
    logic [LEN_W-1:0]  left_q;
    logic [IDX_W-1:0]  aidx_q;
    logic              rep_q;
    logic              restart_q;
    status_e           status_q;
    logic [LEN_W-1:0]  fail_q;
    logic [7:0]        wbyte_q;
    logic [7:0]        rdata_q;
    cmd_e              last_cmd_q;

    logic [6:0]        chip_fold;
    logic [7:0]        addr_byte;
    logic              issuing;
    cmd_e              cmd_code;
    state_e            post_addr;
    logic              rsp_take;

    i2cseq_chipfold #(.ADDR_BYTES(ADDR_BYTES)) u_fold (
        .chip(req_chip), .addr(req_addr), .alen(req_alen),
        .mask(cfg_fold_mask), .chip_out(chip_fold)
    );

    i2cseq_addrbyte #(.ADDR_BYTES(ADDR_BYTES)) u_abyte (
        .addr(addr_q), .idx(aidx_q), .byte_out(addr_byte)
    );

    always_comb begin
        issuing  = 1'b0;
        cmd_code = CMD_START;
        cmd_byte = 8'h00;
        case (state)
            S_START:   begin issuing = 1'b1; cmd_code = CMD_START; end
            S_MIDSTOP,
            S_STOP:    begin issuing = 1'b1; cmd_code = CMD_STOP; end
            S_CHIPW:   begin issuing = 1'b1; cmd_code = CMD_WRITE; cmd_byte = dev_frame(chip_q, 1'b0); end
            S_CHIPR:   begin issuing = 1'b1; cmd_code = CMD_WRITE; cmd_byte = dev_frame(chip_q, 1'b1); end
            S_ADDR:    begin issuing = 1'b1; cmd_code = CMD_WRITE; cmd_byte = addr_byte; end
            S_WDATA:   begin issuing = 1'b1; cmd_code = CMD_WRITE; cmd_byte = wbyte_q; end
            S_RDATA:   begin issuing = 1'b1; cmd_code = CMD_READ; end
            default:   ;
        endcase
    end

    assign cmd_valid     = issuing && !waiting;
    assign cmd_op        = cmd_code;
    assign cmd_nack      = (state == S_RDATA) && (left_q == LEN_W'(1));
    assign wr_ready      = (state == S_WFETCH);
    assign rd_valid      = (state == S_RDOUT);
    assign rd_data       = rdata_q;
    assign req_ready     = (state == S_IDLE);
    assign done_valid    = (state == S_DONE);
    assign done_status   = status_q;
    assign done_fail_cnt = fail_q;
    assign rsp_take      = waiting && rsp_valid;

    always_comb begin
        if (op_q == OP_WRITE)
            post_addr = (left_q != '0) ? S_WFETCH : S_STOP;
        else
            post_addr = rep_q ? S_START : S_MIDSTOP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            waiting    <= 1'b0;
            op_q       <= OP_PROBE;
            chip_q     <= '0;
            addr_q     <= '0;
            alen_q     <= '0;
            left_q     <= '0;
            aidx_q     <= '0;
            rep_q      <= 1'b0;
            restart_q  <= 1'b0;
            status_q   <= ST_OK;
            fail_q     <= '0;
            wbyte_q    <= '0;
            rdata_q    <= '0;
            last_cmd_q <= CMD_START;
        end else begin
            if (cmd_valid && cmd_ready) begin
                waiting    <= 1'b1;
                last_cmd_q <= cmd_code;
            end
            if (rsp_take) waiting <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    case (req_op)
                        2'd1:    op_q <= OP_WRITE;
                        2'd2:    op_q <= OP_READ;
                        default: op_q <= OP_PROBE;
                    endcase
                    chip_q    <= chip_fold;
                    addr_q    <= req_addr;
                    alen_q    <= req_alen;
                    left_q    <= req_len;
                    rep_q     <= cfg_rep_start;
                    restart_q <= 1'b0;
                    status_q  <= ST_OK;
                    fail_q    <= '0;
                    state     <= S_START;
                end
                S_START: if (rsp_take)
                    state <= (restart_q || (op_q == OP_READ && alen_q == '0)) ? S_CHIPR : S_CHIPW;
                S_CHIPW: if (rsp_take) begin
                    if (rsp_nack) begin
                        status_q <= ST_NODEV;
                        state    <= S_STOP;
                    end else if (op_q == OP_PROBE) begin
                        state <= S_STOP;
                    end else if (alen_q != '0) begin
                        aidx_q <= IDX_W'(alen_q - ALEN_W'(1));
                        state  <= S_ADDR;
                    end else begin
                        state <= post_addr;
                        if (post_addr == S_START) restart_q <= 1'b1;
                    end
                end
                S_ADDR: if (rsp_take) begin
                    if (rsp_nack) begin
                        status_q <= ST_ADDR_NACK;
                        state    <= S_STOP;
                    end else if (aidx_q != '0) begin
                        aidx_q <= aidx_q - IDX_W'(1);
                    end else begin
                        state <= post_addr;
                        if (post_addr == S_START) restart_q <= 1'b1;
                    end
                end
                S_MIDSTOP: if (rsp_take) begin
                    restart_q <= 1'b1;
                    state     <= S_START;
                end
                S_CHIPR: if (rsp_take) begin
                    if (rsp_nack) status_q <= ST_NODEV;
                    state <= (left_q != '0) ? S_RDATA : S_STOP;
                end
                S_WFETCH: if (wr_valid) begin
                    wbyte_q <= wr_data;
                    state   <= S_WDATA;
                end
                S_WDATA: if (rsp_take) begin
                    if (rsp_nack) begin
                        fail_q   <= fail_q + LEN_W'(1);
                        status_q <= ST_DATA_NACK;
                    end
                    left_q <= left_q - LEN_W'(1);
                    state  <= (left_q == LEN_W'(1)) ? S_STOP : S_WFETCH;
                end
                S_RDATA: if (rsp_take) begin
                    rdata_q <= rsp_data;
                    state   <= S_RDOUT;
                end
                S_RDOUT: if (rd_ready) begin
                    left_q <= left_q - LEN_W'(1);
                    state  <= (left_q == LEN_W'(1)) ? S_STOP : S_RDATA;
                end
                S_STOP: if (rsp_take) state <= S_DONE;
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte))); // R13
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R8
    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (last_cmd_q == CMD_STOP)); // R2
    AST_FAIL_MATCH: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> ((done_status == ST_DATA_NACK) == (done_fail_cnt != '0))); // R5
    AST_NO_WR_OUTSIDE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (op_q == OP_WRITE)); // R5

endmodule

// File: tb/tb_i2cseq_top.sv
`timescale 1ns/1ps
module tb_i2cseq_top;
    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  chip;
        logic [31:0] addr;
        logic [2:0]  alen;
        logic [7:0]  len;
        logic [15:0] nmask;
        logic        rep;
        logic [6:0]  fold;
        logic [1:0]  exp_st;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 7'h50, 32'h0,        3'd2, 8'd3, 16'h0000, 1'b0, 7'h00, 2'd0},
        '{2'd0, 7'h21, 32'h0,        3'd0, 8'd0, 16'h0001, 1'b0, 7'h00, 2'd1},
        '{2'd1, 7'h50, 32'h1234,     3'd2, 8'd3, 16'h0000, 1'b0, 7'h00, 2'd0},
        '{2'd1, 7'h51, 32'h1234,     3'd2, 8'd2, 16'h0001, 1'b0, 7'h00, 2'd1},
        '{2'd1, 7'h50, 32'hABCD,     3'd2, 8'd2, 16'h0004, 1'b0, 7'h00, 2'd2},
        '{2'd1, 7'h52, 32'h0007,     3'd1, 8'd3, 16'h0014, 1'b0, 7'h00, 2'd3},
        '{2'd2, 7'h50, 32'h0040,     3'd1, 8'd3, 16'h0000, 1'b0, 7'h00, 2'd0},
        '{2'd2, 7'h50, 32'h1F00,     3'd2, 8'd2, 16'h0000, 1'b1, 7'h00, 2'd0},
        '{2'd2, 7'h48, 32'h0,        3'd0, 8'd2, 16'h0000, 1'b0, 7'h00, 2'd0},
        '{2'd2, 7'h48, 32'h0,        3'd0, 8'd1, 16'h0001, 1'b0, 7'h00, 2'd1},
        '{2'd2, 7'h50, 32'h0010,     3'd1, 8'd0, 16'h0000, 1'b0, 7'h00, 2'd0},
        '{2'd1, 7'h50, 32'h03A5,     3'd1, 8'd1, 16'h0000, 1'b0, 7'h03, 2'd0},
        '{2'd1, 7'h20, 32'h89ABCDEF, 3'd4, 8'd1, 16'h0000, 1'b0, 7'h00, 2'd0},
        '{2'd2, 7'h50, 32'h02C4,     3'd1, 8'd1, 16'h0000, 1'b0, 7'h07, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [1:0]  req_op;
    logic [6:0]  req_chip;
    logic [31:0] req_addr;
    logic [2:0]  req_alen;
    logic [7:0]  req_len;
    logic        cfg_rep_start;
    logic [6:0]  cfg_fold_mask;
    logic        wr_valid, wr_ready;
    logic [7:0]  wr_data;
    logic        rd_valid, rd_ready;
    logic [7:0]  rd_data;
    logic        cmd_valid, cmd_ready;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        cmd_nack;
    logic        rsp_valid, rsp_nack;
    logic [7:0]  rsp_data;
    logic        done_valid;
    logic [1:0]  done_status;
    logic [7:0]  done_fail_cnt;

    always #2.5 clk = ~clk;

    i2cseq_top dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_chip(req_chip), .req_addr(req_addr), .req_alen(req_alen), .req_len(req_len),
        .cfg_rep_start(cfg_rep_start), .cfg_fold_mask(cfg_fold_mask),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_data(rsp_data),
        .done_valid(done_valid), .done_status(done_status), .done_fail_cnt(done_fail_cnt)
    );

    // engine model and monitors
    logic        mon_clr;
    logic [15:0] nmask;
    logic [10:0] log_q [40];
    int          log_n, wcount, rcount, widx, rcap_n;
    logic [7:0]  rcap [16];

    assign wr_valid = 1'b1;
    assign wr_data  = 8'h30 + 8'(widx);

    always @(posedge clk) begin
        if (mon_clr) begin
            log_n <= 0; wcount <= 0; rcount <= 0; widx <= 0; rcap_n <= 0;
            rsp_valid <= 1'b0; rsp_nack <= 1'b0; rsp_data <= 8'h00;
        end else begin
            rsp_valid <= 1'b0;
            if (cmd_valid && cmd_ready) begin
                if (log_n < 40)
                    log_q[log_n] <= {cmd_op, (cmd_op == 2'd3) ? cmd_nack : 1'b0,
                                     (cmd_op == 2'd2) ? cmd_byte : 8'h00};
                log_n     <= log_n + 1;
                rsp_valid <= 1'b1;
                rsp_nack  <= (cmd_op == 2'd2 && wcount < 16) ? nmask[wcount] : 1'b0;
                rsp_data  <= 8'hA0 + 8'(rcount);
                if (cmd_op == 2'd2) wcount <= wcount + 1;
                if (cmd_op == 2'd3) rcount <= rcount + 1;
            end
            if (rd_valid && rd_ready) begin
                if (rcap_n < 16) rcap[rcap_n] <= rd_data;
                rcap_n <= rcap_n + 1;
            end
            if (wr_valid && wr_ready) widx <= widx + 1;
        end
    end

    // expected transcript, built from the requirements
    logic [10:0] exp_q [40];
    int          exp_n;
    logic [7:0]  exp_rd [16];
    int          exp_rd_n;
    int          exp_fail;
    int          n_chk = 0;
    int          n_fail = 0;

    task automatic push(input logic [10:0] e);
        exp_q[exp_n] = e;
        exp_n++;
    endtask

    task automatic build_exp(input vec_t v);
        int          wi;
        logic [63:0] a64;
        logic [6:0]  c;
        logic        nk;
        exp_n = 0; exp_rd_n = 0; exp_fail = 0; wi = 0;
        a64 = {32'd0, v.addr};
        c = v.chip | (7'(a64 >> (8 * int'(v.alen))) & v.fold);
        push({2'd0, 9'd0});
        if (!(v.op == 2'd2 && v.alen == 3'd0)) begin
            push({2'd2, 1'b0, c, 1'b0});
            nk = v.nmask[wi]; wi++;
            if (nk || v.op == 2'd0) begin push({2'd1, 9'd0}); return; end
            for (int k = int'(v.alen) - 1; k >= 0; k--) begin
                push({2'd2, 1'b0, 8'(a64 >> (8 * k))});
                nk = v.nmask[wi]; wi++;
                if (nk) begin push({2'd1, 9'd0}); return; end
            end
            if (v.op == 2'd1) begin
                for (int k = 0; k < int'(v.len); k++) begin
                    push({2'd2, 1'b0, 8'h30 + 8'(k)});
                    if (v.nmask[wi]) exp_fail++;
                    wi++;
                end
                push({2'd1, 9'd0});
                return;
            end
            if (!v.rep) push({2'd1, 9'd0});
            push({2'd0, 9'd0});
        end
        push({2'd2, 1'b0, c, 1'b1});
        for (int k = 0; k < int'(v.len); k++) begin
            push({2'd3, (k == int'(v.len) - 1), 8'h00});
            exp_rd[k] = 8'hA0 + 8'(k);
            exp_rd_n++;
        end
        push({2'd1, 9'd0});
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0, 1:    return "R1";
            2, 12:   return "R3";
            3:       return "R2";
            4:       return "R4";
            5:       return "R5";
            6:       return "R6 R8";
            7:       return "R6 R3";
            8:       return "R7 R8";
            9:       return "R10";
            10:      return "R11";
            11:      return "R9";
            default: return "R9 R6";
        endcase
    endfunction

    task automatic clear_mon();
        @(negedge clk) mon_clr = 1'b1;
        @(negedge clk) mon_clr = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input string tag, input int stall);
        int         cyc;
        logic [1:0] st;
        logic [7:0] fc;
        int         bad;
        clear_mon();
        nmask = v.nmask;
        build_exp(v);
        @(negedge clk);
        req_op = v.op; req_chip = v.chip; req_addr = v.addr; req_alen = v.alen;
        req_len = v.len; cfg_rep_start = v.rep; cfg_fold_mask = v.fold;
        req_valid = 1'b1;
        if (stall > 0) cmd_ready = 1'b0;
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (stall > 0) begin
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check(cmd_valid == 1'b1 && cmd_op == 2'd0, "R13", "command held while stalled",
                      {cmd_valid, cmd_op}, 3'b100);
            end
            cmd_ready = 1'b1;
        end
        cyc = 0;
        @(negedge clk);
        while (!done_valid && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_valid) begin
            check(1'b0, tag, "watchdog expired", cyc, 3000);
            return;
        end
        st = done_status;
        fc = done_fail_cnt;
        check(st == v.exp_st, tag, "status", st, v.exp_st);
        check(fc == 8'(exp_fail), tag, "fail count", fc, exp_fail);
        bad = -1;
        for (int k = 0; k < exp_n; k++)
            if (bad < 0 && (k >= log_n || log_q[k] !== exp_q[k])) bad = k;
        if (log_n != exp_n)
            check(1'b0, tag, "transcript length", log_n, exp_n);
        else if (bad >= 0)
            check(1'b0, tag, $sformatf("transcript entry %0d", bad), log_q[bad], exp_q[bad]);
        else
            check(1'b1, tag, "transcript", 0, 0);
        bad = -1;
        for (int k = 0; k < exp_rd_n; k++)
            if (bad < 0 && rcap[k] !== exp_rd[k]) bad = k;
        check(rcap_n == exp_rd_n && bad < 0, tag, "read data",
              (bad < 0) ? rcap_n : rcap[bad], (bad < 0) ? exp_rd_n : exp_rd[bad]);
    endtask

    initial begin
        rst = 1'b1; mon_clr = 1'b1; req_valid = 1'b0; req_op = '0; req_chip = '0;
        req_addr = '0; req_alen = '0; req_len = '0; cfg_rep_start = 1'b0;
        cfg_fold_mask = '0; rd_ready = 1'b1; cmd_ready = 1'b1; nmask = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mon_clr = 1'b0;
        @(negedge clk);
        // R12: idle after reset
        check(req_ready == 1'b1, "R12", "req_ready after reset", req_ready, 1);
        check(cmd_valid == 1'b0, "R12", "cmd_valid after reset", cmd_valid, 0);
        check(done_valid == 1'b0 && rd_valid == 1'b0 && wr_ready == 1'b0, "R12",
              "done/rd/wr after reset", {done_valid, rd_valid, wr_ready}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], tag_of(i), 0);

        // R13: engine not ready for several cycles, no command lost or repeated
        run_vec(VECS[0], "R13", 5);

        // R12: reset in the middle of a transfer returns to idle
        @(negedge clk);
        req_op = 2'd1; req_chip = 7'h50; req_alen = 3'd2; req_len = 8'd3; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && cmd_valid == 1'b0, "R12", "idle after mid-transfer reset",
              {req_ready, cmd_valid}, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule